// File: doc/BRIEF.md
# Eviction Write Buffer

This block sits between a write-back cache and a slow physical memory that moves one whole line per transfer. When the cache evicts a dirty line, it normally has to wait for that line to be written out before it can fetch the line it actually missed on. With this block in place, the evicted line and its address are held in a local one-line store, and the cache gets its response one cycle later. The refill read then goes to memory first. The held line is written back after that read has returned, so the writeback overlaps the requester's use of the refilled data.

The cache side has read and write strobes, a byte address, a line of write data, a line of read data and a one-cycle response. A request is held until its response arrives. The memory side has the same shape: a read or write strobe is held until the memory raises its response for one cycle. Line width is a parameter. The default is 128 bits, and a 256-bit configuration is built by changing it; memory latency is the memory's own business. The line address is the part of the address above log2(LINE_W/8) offset bits. Addresses sent to memory carry a zero offset.

Top module: `evict_wbuf`

## Requirements
- R1: After reset, `c_resp`, `m_read` and `m_write` are low and the store is empty.
- R2: A cache write to an empty store, presented while the block is idle, is captured with no memory transaction and answered by `c_resp` on the first clock edge. `c_resp` is always a single-cycle pulse.
- R3: A cache read whose line is not held in the store is issued to memory at its line address and held until `m_resp`. The memory data is then returned to the cache with `c_resp` one edge later.
- R4: After a line is captured, a following read miss is issued to memory before the held line is written out.
- R5: Once any read has completed after the capture, the held line is written to memory without any further cache request.
- R6: A read whose line address matches the held line is answered from the store, with no memory read. When the block is idle, the answer comes on the first edge.
- R7: A cache write to the line already held replaces the held data in place. The line later costs exactly one memory write, which carries the newest data.
- R8: A cache write to a different line while the store is occupied is stalled. That write forces the held line out, and it is accepted only after the memory acknowledges the drain write.
- R9: A drain write, once issued, stays asserted with a stable address and data until `m_resp`. Cache reads arriving during it wait, and `m_read` and `m_write` are never high together.
- R10: The store is emptied on the cycle the memory acknowledges the drain write. A later read of that line goes to memory and returns the drained data.
- R11: Every read response carries the most recent data written by the cache for that line, or the memory's own content if the cache never wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_read | input | 1 | Cache line read request, held until `c_resp` |
| c_write | input | 1 | Cache line write (eviction) request, held until `c_resp` |
| c_addr | input | ADDR_W | Cache request byte address |
| c_wdata | input | LINE_W | Line written by the cache |
| c_rdata | output | LINE_W | Line returned to the cache |
| c_resp | output | 1 | One-cycle completion for the cache request |
| m_read | output | 1 | Memory line read strobe |
| m_write | output | 1 | Memory line write strobe |
| m_addr | output | ADDR_W | Memory line address, offset bits zero |
| m_wdata | output | LINE_W | Line written to memory |
| m_rdata | input | LINE_W | Line returned by memory |
| m_resp | input | 1 | One-cycle memory completion |

## Verification
The properties assume a cache that never raises read and write together and holds each request with a steady address until it sees `c_resp`. They also assume a memory that pulses `m_resp` only while one of its strobes is up. The bench's cache driver raises one request per task call and releases it on the sampled response. Its memory model counts latency only while a strobe is present and drops the response after one cycle, so both sides stay within these rules. Read data is checked against a behavioural line map. Memory transactions are logged in order, so read-before-write ordering and single drains can be checked.

// File: rtl/evict_wbuf_pkg.sv
package evict_wbuf_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_READ  = 2'd1,
    MS_WRITE = 2'd2
  } mem_st_e;
endpackage

// File: rtl/evict_wbuf_store.sv
module evict_wbuf_store #(
  parameter int TAG_W  = 12,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              clr_en,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [LINE_W-1:0] in_line,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              vld,
  output logic [TAG_W-1:0]  tag,
  output logic [LINE_W-1:0] line,
  output logic              hit
);
  logic vld_d;

  always_comb begin
    vld_d = vld;
    if (cap_en) vld_d = 1'b1;
    if (clr_en) vld_d = 1'b0;
    hit = vld && (tag == look_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= vld_d;
  end

  // Data and tag carry no reset; they are qualified by vld.
  always_ff @(posedge clk) begin
    if (cap_en) begin
      tag  <= in_tag;
      line <= in_line;
    end
  end
endmodule

// File: rtl/evict_wbuf_ctrl.sv
module evict_wbuf_ctrl
  import evict_wbuf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    c_read,
  input  logic    c_write,
  input  logic    buf_vld,
  input  logic    buf_hit,
  input  logic    m_resp,
  output mem_st_e st,
  output logic    resp_q,
  output logic    cap_en,
  output logic    clr_en,
  output logic    ld_buf_data,
  output logic    ld_mem_data,
  output logic    ld_rd_tag
);
  mem_st_e st_d;
  logic    refill_q, refill_d, resp_d;
  logic    req_ok, rd_hit, rd_miss, wr_take, wr_block, rd_done, drain_go;

  always_comb begin
    req_ok   = (st == MS_IDLE) && !resp_q;
    rd_hit   = req_ok && c_read && buf_hit;
    rd_miss  = req_ok && c_read && !buf_hit;
    wr_take  = req_ok && c_write && (!buf_vld || buf_hit);
    wr_block = req_ok && c_write && buf_vld && !buf_hit;
    rd_done  = (st == MS_READ) && m_resp;
    drain_go = (st == MS_IDLE) && buf_vld && !rd_hit && !rd_miss && !wr_take
               && (refill_q || wr_block);
    clr_en      = (st == MS_WRITE) && m_resp;
    cap_en      = wr_take;
    ld_buf_data = rd_hit;
    ld_mem_data = rd_done;
    ld_rd_tag   = rd_miss;
    resp_d      = rd_hit || wr_take || rd_done;

    st_d = st;
    case (st)
      MS_IDLE: begin
        if (rd_miss)       st_d = MS_READ;
        else if (drain_go) st_d = MS_WRITE;
      end
      MS_READ:  if (m_resp) st_d = MS_IDLE;
      MS_WRITE: if (m_resp) st_d = MS_IDLE;
      default:  st_d = MS_IDLE;
    endcase

    refill_d = refill_q;
    if (rd_hit || rd_done)    refill_d = 1'b1;
    if (wr_take && !buf_vld)  refill_d = 1'b0;
    if (clr_en)               refill_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= MS_IDLE;
      resp_q   <= 1'b0;
      refill_q <= 1'b0;
    end else begin
      st       <= st_d;
      resp_q   <= resp_d;
      refill_q <= refill_d;
    end
  end
endmodule

// File: rtl/evict_wbuf.sv
module evict_wbuf
  import evict_wbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_read,
  input  logic              c_write,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [LINE_W-1:0] c_wdata,
  output logic [LINE_W-1:0] c_rdata,
  output logic              c_resp,
  output logic              m_read,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [LINE_W-1:0] m_wdata,
  input  logic [LINE_W-1:0] m_rdata,
  input  logic              m_resp
);
  localparam int OFS_W = $clog2(LINE_W / 8);
  localparam int TAG_W = ADDR_W - OFS_W;

  mem_st_e           st;
  logic              resp_q, cap_en, clr_en, ld_buf_data, ld_mem_data, ld_rd_tag;
  logic              buf_vld, buf_hit;
  logic [TAG_W-1:0]  c_tag, buf_tag, rd_tag_q, out_tag;
  logic [LINE_W-1:0] buf_line, rdata_q, rdata_d;

  assign c_tag = c_addr[ADDR_W-1:OFS_W];

  evict_wbuf_store #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .clr_en   (clr_en),
    .in_tag   (c_tag),
    .in_line  (c_wdata),
    .look_tag (c_tag),
    .vld      (buf_vld),
    .tag      (buf_tag),
    .line     (buf_line),
    .hit      (buf_hit)
  );

  evict_wbuf_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .c_read      (c_read),
    .c_write     (c_write),
    .buf_vld     (buf_vld),
    .buf_hit     (buf_hit),
    .m_resp      (m_resp),
    .st          (st),
    .resp_q      (resp_q),
    .cap_en      (cap_en),
    .clr_en      (clr_en),
    .ld_buf_data (ld_buf_data),
    .ld_mem_data (ld_mem_data),
    .ld_rd_tag   (ld_rd_tag)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (ld_buf_data)      rdata_d = buf_line;
    else if (ld_mem_data) rdata_d = m_rdata;
    out_tag = (st == MS_WRITE) ? buf_tag : rd_tag_q;
  end

  always_ff @(posedge clk) begin
    rdata_q <= rdata_d;
    if (ld_rd_tag) rd_tag_q <= c_tag;
  end

  assign c_rdata = rdata_q;
  assign c_resp  = resp_q;
  assign m_read  = (st == MS_READ);
  assign m_write = (st == MS_WRITE);
  assign m_addr  = {out_tag, {OFS_W{1'b0}}};
  assign m_wdata = buf_line;
endmodule

// File: rtl/evict_wbuf_chk.sv
module evict_wbuf_chk #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              c_read,
  input logic              c_resp,
  input logic              m_read,
  input logic              m_write,
  input logic              m_resp,
  input logic [ADDR_W-1:0] m_addr,
  input logic [LINE_W-1:0] m_wdata,
  input logic              buf_vld
);
  p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c_resp |=> !c_resp);

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_read && !m_resp) |=> (m_read && $stable(m_addr)));

  p_drain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write && !m_resp) |=> (m_write && $stable(m_addr) && $stable(m_wdata)));

  p_read_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write && c_read) |=> !m_read);

  p_clear_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write && m_resp) |=> !buf_vld);
endmodule

bind evict_wbuf evict_wbuf_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .c_read  (c_read),
  .c_resp  (c_resp),
  .m_read  (m_read),
  .m_write (m_write),
  .m_resp  (m_resp),
  .m_addr  (m_addr),
  .m_wdata (m_wdata),
  .buf_vld (buf_vld)
);

// File: tb/evict_wbuf_tb.sv
module evict_wbuf_tb;
  localparam int ADDR_W = 16;
  localparam int LINE_W = 128;
  localparam int LAT    = 4;
  localparam int OFS_W  = $clog2(LINE_W / 8);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              c_read, c_write;
  logic [ADDR_W-1:0] c_addr;
  logic [LINE_W-1:0] c_wdata, c_rdata;
  logic              c_resp;
  logic              m_read, m_write;
  logic [ADDR_W-1:0] m_addr;
  logic [LINE_W-1:0] m_wdata;
  logic [LINE_W-1:0] m_rdata;
  logic              m_resp;

  int n_chk = 0;
  int n_bad = 0;
  int n_rd  = 0;
  int n_wr  = 0;
  int ev_k[$];
  int ev_a[$];
  logic [LINE_W-1:0] mem_a [int];
  logic [LINE_W-1:0] gold  [int];

  always #5 clk = ~clk;

  evict_wbuf #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .c_read(c_read), .c_write(c_write),
    .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata), .c_resp(c_resp),
    .m_read(m_read), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_resp(m_resp)
  );

  function automatic logic [LINE_W-1:0] pat(input int ln);
    return {(LINE_W/32){32'(ln) ^ 32'hA5A5_0000}};
  endfunction

  function automatic logic [LINE_W-1:0] mk(input int s);
    return {(LINE_W/32){32'(s * 32'h9E37_79B1 + 32'h0000_1234)}};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model and per-clock comparison, both off the active edge.
  int mcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      m_resp = 1'b0;
      mcnt   = 0;
    end else begin
      n_chk++;
      if (m_read && m_write) begin
        n_bad++;
        $display("FAIL R9 strobes: actual both expected one");
      end
      if (m_resp) begin
        m_resp = 1'b0;
        mcnt   = 0;
      end else if (m_read || m_write) begin
        mcnt++;
        if (mcnt >= LAT) begin
          m_resp = 1'b1;
          if (m_write) begin
            mem_a[int'(m_addr >> OFS_W)] = m_wdata;
            n_wr++;
            ev_k.push_back(1);
          end else begin
            m_rdata = mem_a.exists(int'(m_addr >> OFS_W)) ? mem_a[int'(m_addr >> OFS_W)]
                                                          : pat(int'(m_addr >> OFS_W));
            n_rd++;
            ev_k.push_back(0);
          end
          ev_a.push_back(int'(m_addr >> OFS_W));
        end
      end
    end
  end

  task automatic do_read(input int ln, output int lat);
    logic [LINE_W-1:0] exp;
    c_addr = ADDR_W'(ln << OFS_W);
    c_read = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!c_resp);
    exp = gold.exists(ln) ? gold[ln] : pat(ln);
    chk(c_rdata == exp, "R11", "read data", c_rdata, exp);
    c_read = 1'b0;
  endtask

  task automatic do_write(input int ln, input logic [LINE_W-1:0] d, output int lat);
    c_addr  = ADDR_W'(ln << OFS_W);
    c_wdata = d;
    c_write = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!c_resp);
    c_write  = 1'b0;
    gold[ln] = d;
  endtask

  task automatic wait_wr(input int target);
    for (int i = 0; i < 4 * LAT + 8; i++) begin
      if (n_wr >= target) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int lat, r0, w0, e0;
    rst_n = 1'b0; c_read = 1'b0; c_write = 1'b0;
    c_addr = '0; c_wdata = '0; m_rdata = '0; m_resp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!c_resp && !m_read && !m_write, "R1", "outputs after reset",
        {c_resp, m_read, m_write}, 0);

    // R3: plain read miss
    r0 = n_rd;
    do_read(5, lat);
    chk(n_rd == r0 + 1, "R3", "memory reads on miss", n_rd - r0, 1);

    // R2: eviction captured without memory traffic
    @(negedge clk);
    r0 = n_rd; w0 = n_wr;
    do_write(10, mk(1), lat);
    chk(lat == 1, "R2", "capture latency", lat, 1);
    chk(n_rd == r0 && n_wr == w0, "R2", "memory ops on capture", n_rd + n_wr, r0 + w0);

    // R4: refill read before writeback; R5: drain follows by itself
    e0 = ev_k.size();
    do_read(20, lat);
    chk(ev_k.size() == e0 + 1 && ev_k[e0] == 0 && ev_a[e0] == 20, "R4",
        "first memory op after capture", ev_a[e0], 20);
    chk(n_wr == w0, "R4", "writes before refill done", n_wr - w0, 0);
    wait_wr(w0 + 1);
    chk(n_wr == w0 + 1 && ev_a[ev_a.size()-1] == 10, "R5", "drained line",
        ev_a[ev_a.size()-1], 10);
    repeat (2) @(negedge clk);

    // R10: after drain the line comes from memory
    r0 = n_rd;
    do_read(10, lat);
    chk(n_rd == r0 + 1, "R10", "read after drain goes to memory", n_rd - r0, 1);

    // R7: merge two writes to one line
    @(negedge clk);
    w0 = n_wr;
    do_write(30, mk(2), lat);
    @(negedge clk);
    do_write(30, mk(3), lat);
    chk(lat == 1 && n_wr == w0, "R7", "merge latency and no write", lat, 1);
    do_read(31, lat);
    wait_wr(w0 + 1);
    repeat (3 * LAT) @(negedge clk);
    chk(n_wr == w0 + 1, "R7", "writes for merged line", n_wr - w0, 1);
    chk(mem_a.exists(30) && mem_a[30] == mk(3), "R7", "merged data in memory",
        mem_a.exists(30) ? mem_a[30] : '0, mk(3));

    // R6: hit in store
    w0 = n_wr;
    do_write(40, mk(4), lat);
    @(negedge clk);
    r0 = n_rd;
    do_read(40, lat);
    chk(lat == 1, "R6", "hit latency", lat, 1);
    chk(n_rd == r0, "R6", "memory reads on hit", n_rd - r0, 0);
    wait_wr(w0 + 1);
    repeat (2) @(negedge clk);

    // R8: second eviction stalls until first is drained
    @(negedge clk);
    do_write(50, mk(5), lat);
    w0 = n_wr;
    do_write(60, mk(6), lat);
    chk(n_wr == w0 + 1 && ev_k[ev_k.size()-1] == 1 && ev_a[ev_a.size()-1] == 50,
        "R8", "drain before second capture", ev_a[ev_a.size()-1], 50);
    chk(lat > LAT, "R8", "stall length", lat, LAT + 1);

    // R9: read arriving during a drain waits for it
    e0 = ev_k.size();
    do_read(70, lat);
    do_read(80, lat);
    chk(ev_k.size() >= e0 + 3 && ev_a[e0] == 70 && ev_k[e0+1] == 1 && ev_a[e0+1] == 60
        && ev_k[e0+2] == 0 && ev_a[e0+2] == 80, "R9", "read, drain, read order",
        ev_a[e0+2], 80);
    do_read(60, lat);

    // R11: mixed traffic
    for (int i = 0; i < 24; i++) begin
      if (i % 3 == 0) do_write(100 + (i % 5), mk(10 + i), lat);
      else            do_read(100 + ((i * 7) % 6), lat);
    end
    do_read(999, lat);
    repeat (4 * LAT + 8) @(negedge clk);
    foreach (gold[k]) begin
      chk(mem_a.exists(k) && mem_a[k] == gold[k], "R11", "memory content after flush",
          mem_a.exists(k) ? mem_a[k] : '0, gold[k]);
    end

    summary();
    $finish;
  end
endmodule